// File: doc/BRIEF.md
# Quad-Line Serial Flash Read Sequencer

This block runs one complete quad-I/O fast read from a serial flash. After a start request it lowers chip select and shifts the command byte out serially on data line 0. Then, in the same transaction, it switches to all four data lines. It sends the 24-bit address and a mode byte four bits per serial clock. It then issues a fixed number of turnaround clocks with every host driver off. Finally it samples read data four bits per serial clock and joins each pair of nibbles into a byte, which it presents with a one-cycle strobe. When the requested number of bytes has arrived, chip select goes high and a done pulse is issued.

The serial clock runs at half the system clock, so each serial clock has one system cycle low and one high, with an idle-low polarity. Outputs change while the serial clock is low, and read data is sampled at the system edge that raises it. Separate per-line enables control the external tristate pads. Line 0 serves as the serial input line during the command phase. Lines 2 and 3 are the lines that otherwise carry write-protect and hold.

The controller is a six-state machine. IDLE goes to CMD on an accepted start. CMD goes to ADDR after 8 serial clocks. ADDR goes to DUMMY after 8 serial clocks. DUMMY goes to DATA after `DUMMY_CLKS` serial clocks. DATA goes to FINISH on the falling half of the clock that completes the last byte. FINISH goes back to IDLE after one cycle.

Top module: `qspi_fastread_eng`

## Requirements
- R1: After reset and whenever idle, cs_n is 1, sclk is 0, sio_oe is 4'b0000, busy is 0 and rd_valid is 0; sclk never pulses while cs_n is high.
- R2: The first 8 serial clocks of a transaction carry the command byte 0xEB on sio_out[0], most significant bit first, with sio_oe = 4'b0001.
- R3: The next 8 serial clocks carry the 24-bit address followed by the mode byte 0x00, one nibble per clock, most significant nibble first, with sio_out[3] holding the nibble's top bit and sio_oe = 4'b1111.
- R4: The next 4 serial clocks are turnaround clocks with sio_oe = 4'b0000. The lines stay released through the data phase.
- R5: In the data phase one nibble is sampled from sio_in at each sclk rise, high nibble first, sio_in[3] being the nibble's top bit. Each byte appears on rd_data with a one-cycle rd_valid, and strobes are spaced 4 system cycles apart.
- R6: Exactly rd_len bytes are delivered, using 20 + 2*rd_len serial clocks in total. Then cs_n rises and done pulses for one cycle.
- R7: cs_n stays low without a break from the first command clock to the last data clock, and it rises only together with done.
- R8: A start is ignored while busy, or when rd_len is 0; it neither starts nor alters a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a read (sampled while idle) |
| rd_addr | input | 24 | Flash byte address of the first byte |
| rd_len | input | 16 | Number of bytes to read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when chip select returns high |
| rd_data | output | 8 | Assembled read byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Chip select, active low |
| sio_out | output | 4 | Values driven on the four data lines |
| sio_oe | output | 4 | Per-line output enable for the pads |
| sio_in | input | 4 | Values sampled from the four data lines |

## Verification
A flash model in the bench counts serial clocks. It decodes the command and address nibbles and drives read nibbles from a computed byte pattern. Random addresses and lengths from 1 to 9 test the nibble order and the byte count together, because a swapped nibble or a wrong address changes every byte. Directed runs check the single-byte case, the last address in the map, and a 16-byte burst that checks strobe spacing. A zero length and a start raised in mid-transaction are also applied; either one would show up as a changed byte count or a changed address.

// File: rtl/qfr_pkg.sv
package qfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_FINISH
    } qfr_state_e;

    localparam logic [7:0] QFR_OPCODE  = 8'hEB;
    localparam logic [7:0] QFR_MODE    = 8'h00;
    localparam int         QFR_CMD_CLKS = 8;

endpackage

// File: rtl/qfr_sclk_phase.sv
module qfr_sclk_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ph,
    output logic rise,
    output logic fall
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= 1'b0;
        end else if (run) begin
            ph <= ~ph;
        end else begin
            ph <= 1'b0;
        end
    end

    // rise: the edge ending this cycle raises sclk; fall: it lowers sclk
    assign rise = run & ~ph;
    assign fall = run & ph;
endmodule

// File: rtl/qfr_tx_shift.sv
module qfr_tx_shift #(
    parameter int TX_W = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_val,
    input  logic            shift1,
    input  logic            shift4,
    output logic [3:0]      top
);
    logic [TX_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift4) begin
            sr <= {sr[TX_W-5:0], 4'b0000};
        end else if (shift1) begin
            sr <= {sr[TX_W-2:0], 1'b0};
        end
    end

    assign top = sr[TX_W-1 -: 4];
endmodule

// File: rtl/qfr_rx_pack.sv
module qfr_rx_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       capture,
    input  logic [3:0] nib_in,
    output logic       half,
    output logic [7:0] byte_out,
    output logic       byte_valid
);
    logic [3:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q       <= '0;
            half       <= 1'b0;
            byte_out   <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (clr) begin
                half <= 1'b0;
            end else if (capture) begin
                if (!half) begin
                    hi_q <= nib_in;
                    half <= 1'b1;
                end else begin
                    byte_out   <= {hi_q, nib_in};
                    byte_valid <= 1'b1;
                    half       <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/qspi_fastread_eng.sv
module qspi_fastread_eng #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int DUMMY_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [LEN_W-1:0]  rd_len,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        sio_out,
    output logic [3:0]        sio_oe,
    input  logic [3:0]        sio_in
);
    import qfr_pkg::*;

    localparam int TX_W      = 8 + ADDR_W + 8;
    localparam int ADDR_CLKS = (ADDR_W + 8) / 4;
    localparam int MAX_CLKS  = (ADDR_CLKS > DUMMY_CLKS) ? ADDR_CLKS : DUMMY_CLKS;
    localparam int CNT_W     = $clog2(MAX_CLKS + 1);
    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(QFR_CMD_CLKS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_CLKS - 1);
    localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CLKS - 1);

    qfr_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] bytes_left;
    logic             run, ph, rise, fall;
    logic             accept, capture, half, byte_done;
    logic [3:0]       tx_top;

    assign accept    = (state == ST_IDLE) && start && (rd_len != '0);
    assign run       = (state == ST_CMD) || (state == ST_ADDR) ||
                       (state == ST_DUMMY) || (state == ST_DATA);
    assign capture   = rise && (state == ST_DATA);
    assign byte_done = capture && half;

    qfr_sclk_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .ph    (ph),
        .rise  (rise),
        .fall  (fall)
    );

    qfr_tx_shift #(.TX_W(TX_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val ({QFR_OPCODE, rd_addr, QFR_MODE}),
        .shift1   (fall && (state == ST_CMD)),
        .shift4   (fall && (state == ST_ADDR)),
        .top      (tx_top)
    );

    qfr_rx_pack u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (accept),
        .capture    (capture),
        .nib_in     (sio_in),
        .half       (half),
        .byte_out   (rd_data),
        .byte_valid (rd_valid)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_CMD;
            ST_CMD:    if (fall && cnt == CMD_LAST) state_nx = ST_ADDR;
            ST_ADDR:   if (fall && cnt == ADDR_LAST) state_nx = ST_DUMMY;
            ST_DUMMY:  if (fall && cnt == DUMMY_LAST) state_nx = ST_DATA;
            ST_DATA:   if (fall && !half && bytes_left == '0) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // clock counter within a phase and remaining byte count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            bytes_left <= '0;
        end else begin
            if (state != state_nx) begin
                cnt <= '0;
            end else if (fall && state != ST_DATA) begin
                cnt <= cnt + 1'b1;
            end
            if (accept) begin
                bytes_left <= rd_len;
            end else if (byte_done) begin
                bytes_left <= bytes_left - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        done    = (state == ST_FINISH);
        cs_n    = (state == ST_IDLE) || (state == ST_FINISH);
        sclk    = run && ph;
        sio_out = 4'b0000;
        sio_oe  = 4'b0000;
        unique case (state)
            ST_CMD: begin
                sio_out = {3'b000, tx_top[3]};
                sio_oe  = 4'b0001;
            end
            ST_ADDR: begin
                sio_out = tx_top;
                sio_oe  = 4'b1111;
            end
            default: begin
                sio_out = 4'b0000;
                sio_oe  = 4'b0000;
            end
        endcase
    end
endmodule

// File: rtl/qfr_chk.sv
module qfr_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] rd_len,
    input logic             busy,
    input logic             done,
    input logic             rd_valid,
    input logic             sclk,
    input logic             cs_n,
    input logic [3:0]       sio_oe
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sclk && sio_oe == 4'b0000 && !rd_valid));

    assert_oe_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_oe == 4'b0000 || sio_oe == 4'b0001 || sio_oe == 4'b1111));

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_strobe_in_txn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n);

    assert_done_cs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && busy));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_cs_rise_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);

    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && rd_len == '0) |=> !busy);
endmodule

bind qspi_fastread_eng qfr_chk #(.LEN_W(LEN_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_len   (rd_len),
    .busy     (busy),
    .done     (done),
    .rd_valid (rd_valid),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .sio_oe   (sio_oe)
);

// File: tb/qspi_fastread_eng_tb_top.sv
`timescale 1ns/1ps
module qspi_fastread_eng_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] rd_addr = '0;
    logic [15:0] rd_len = '0;
    logic        busy, done, rd_valid, sclk, cs_n;
    logic [7:0]  rd_data;
    logic [3:0]  sio_out, sio_oe;
    logic [3:0]  sio_in = 4'h0;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    qspi_fastread_eng dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr), .rd_len(rd_len),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_valid(rd_valid),
        .sclk(sclk), .cs_n(cs_n), .sio_out(sio_out), .sio_oe(sio_oe), .sio_in(sio_in)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hC3;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // flash model: decodes host lines on sclk rise, drives read nibbles on sclk fall
    int          edges;
    logic [7:0]  cmd_cap;
    logic [31:0] am_cap;
    int          e_cmd, e_addr, e_dum, e_dat;

    always @(posedge sclk or negedge cs_n) begin
        if (!sclk) begin
            edges = 0; cmd_cap = '0; am_cap = '0;
            e_cmd = 0; e_addr = 0; e_dum = 0; e_dat = 0;
        end else if (!cs_n) begin
            edges++;
            if (edges <= 8) begin
                cmd_cap = {cmd_cap[6:0], sio_out[0]};
                if (sio_oe != 4'b0001) e_cmd++;
            end else if (edges <= 16) begin
                am_cap = {am_cap[27:0], sio_out};
                if (sio_oe != 4'b1111) e_addr++;
            end else if (edges <= 20) begin
                if (sio_oe != 4'b0000) e_dum++;
            end else begin
                if (sio_oe != 4'b0000) e_dat++;
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n && edges >= 20) begin
            int idx;
            logic [7:0] b;
            idx = edges - 20;
            b = mem_byte(am_cap[31:8] + 24'(idx / 2));
            sio_in = (idx % 2 == 1) ? b[3:0] : b[7:4];
        end
    end

    task automatic run_xfer(input logic [23:0] a, input logic [15:0] n, input bit poke);
        int got = 0;
        int last_cyc = 0;
        int cyc = 0;
        bit seen_done = 0;
        @(negedge clk);
        rd_addr = a; rd_len = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!cs_n && busy, "R7 cs_n low after start", {30'd0, cs_n, busy}, 32'h1);
        while (cyc < 2000) begin
            if (poke && cyc == 10) begin
                rd_addr = a ^ 24'h00F0F0; rd_len = 16'd3; start = 1'b1;
            end else if (poke && cyc == 11) begin
                start = 1'b0;
            end
            if (rd_valid) begin
                chk(rd_data == mem_byte(a + 24'(got)), "R5 byte value", rd_data, mem_byte(a + 24'(got)));
                if (got > 0)
                    chk(cyc - last_cyc == 4, "R5 strobe spacing", cyc - last_cyc, 4);
                last_cyc = cyc;
                got++;
            end
            if (done) begin
                seen_done = 1;
                break;
            end
            if (cs_n) chk(0, "R7 cs_n high before done", cs_n, 0);
            @(negedge clk);
            cyc++;
        end
        chk(seen_done, "R6 done seen", seen_done, 1);
        chk(got == int'(n), "R6 byte count", got, n);
        chk(edges == 20 + 2 * int'(n), "R6 serial clock count", edges, 20 + 2 * n);
        chk(cmd_cap == 8'hEB, "R2 command byte", cmd_cap, 8'hEB);
        chk(e_cmd == 0, "R2 command enables", e_cmd, 0);
        chk(am_cap[31:8] == a, "R3 address", am_cap[31:8], a);
        chk(am_cap[7:0] == 8'h00, "R3 mode byte", am_cap[7:0], 0);
        chk(e_addr == 0, "R3 address enables", e_addr, 0);
        chk(e_dum == 0 && e_dat == 0, "R4 released lines", e_dum + e_dat, 0);
        @(negedge clk);
        chk(!busy && cs_n && !done, "R6 idle after done", {29'd0, busy, cs_n, done}, 32'h2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED1);
        @(negedge clk);
        chk(cs_n && !sclk && sio_oe == 0 && !busy && !rd_valid, "R1 in reset",
            {27'd0, cs_n, sclk, busy, rd_valid, |sio_oe}, 32'h10);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !sclk && sio_oe == 0 && !busy && !rd_valid, "R1 after reset",
            {27'd0, cs_n, sclk, busy, rd_valid, |sio_oe}, 32'h10);

        // R8: zero length is ignored
        rd_addr = 24'h123456; rd_len = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk(!busy && cs_n && !sclk, "R8 zero length ignored", {30'd0, busy, cs_n}, 32'h1);
            @(negedge clk);
        end

        // directed corners
        run_xfer(24'h000000, 16'd1, 1'b0);
        run_xfer(24'hFFFFFF, 16'd2, 1'b0);
        run_xfer(24'h000000, 16'd16, 1'b0);
        // R8: start during a transaction is ignored
        run_xfer(24'hA5C381, 16'd5, 1'b1);

        // random transactions
        for (int t = 0; t < 8; t++) begin
            logic [23:0] a;
            logic [15:0] n;
            a = 24'($urandom);
            n = 16'(1 + $urandom % 9);
            run_xfer(a, n, 1'b0);
        end

        chk(cs_n && !sclk && sio_oe == 0, "R1 idle at end", {29'd0, cs_n, sclk, |sio_oe}, 32'h4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule